// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave-side protocol engine for a 1024-byte serial memory on a two-wire bus. A fast system clock oversamples the bus clock and data lines. The engine recognises start and stop conditions and decodes the device select byte, which carries a 4-bit type code, a chip select bit, the two upper memory address bits and the direction bit. It acknowledges accepted bytes by enabling an open-drain pull-down, and it shifts read data out most significant bit first. It also keeps the internal address counter. Read data comes from a combinational byte-wide read port that is addressed by the counter. Each written byte goes out as a one-cycle request to a separate page buffer, and a commit pulse tells that buffer to start its nonvolatile write. While the commit is in progress the buffer holds `busy_in` high, and during that time the engine stays silent so that a master can poll for completion.

The state machine has nine states. `ST_IDLE` is standby. `ST_DEV`, `ST_ADR` and `ST_WR` receive the device byte, the low address byte and the data bytes. `ST_DEV_ACK`, `ST_ADR_ACK` and `ST_WR_ACK` drive the acknowledge bit. `ST_RD` shifts out a read byte, and `ST_RD_ACK` samples the master's answer.

The transitions are as follows:
- A start moves any state to `ST_DEV`.
- A stop or `busy_in` moves any state to `ST_IDLE`.
- In `ST_DEV`, the eighth bit leads to `ST_DEV_ACK` on a match, or to `ST_IDLE` otherwise.
- `ST_DEV_ACK` goes to `ST_RD` or `ST_ADR`, depending on the direction bit.
- `ST_ADR` goes to `ST_ADR_ACK`, and `ST_ADR_ACK` goes to `ST_WR`.
- `ST_WR` and `ST_WR_ACK` alternate.
- `ST_RD` goes to `ST_RD_ACK`. From `ST_RD_ACK` the engine returns to `ST_RD` if the master acknowledges, or drops to `ST_IDLE` if it does not.

Top module: `twm_eeprom_slave`

## Requirements
- R1: After reset the engine is in standby with the pull-down off and no write request. A falling SDA while SCL is high (start) restarts device byte reception from any state. A rising SDA while SCL is high (stop) returns to standby and releases SDA.
- R2: Device byte bits are sent MSB first as [7:4] type code 1010, [3] select, [2:1] address bits 9:8, and [0] direction (1 = read). The engine acknowledges only if the code matches and bit 3 equals `sel_a2`. Otherwise it stays silent until the next start.
- R3: An acknowledge pulls SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth. The pull-down changes only while the synchronised SCL is low.
- R4: In a write, the device byte, the address byte and every data byte are acknowledged. Each data byte produces a one-cycle `wr_valid` with `wr_addr` equal to the counter, after which the counter increments.
- R5: A write's address byte loads the counter with {device byte bits 2:1, address byte}.
- R6: A read returns the byte at the counter on `mem_raddr`, MSB first, with each bit presented after an SCL fall. The counter increments once the byte has been shifted out.
- R7: If the master acknowledges a read byte, the next byte follows. If it does not, the engine releases SDA and waits in standby.
- R8: The counter rolls over from 1023 to 0, both in writes and in reads.
- R9: A write that carries only an address byte, followed by a repeated start with a read device byte, reads from the loaded address.
- R10: While `busy_in` is high nothing is acknowledged, not even a matching device byte, and the pull-down is off one cycle after `busy_in` is seen.
- R11: A stop that follows at least one complete data byte since the previous stop produces a one-cycle `wr_commit`. A stop with no data byte produces none.
- R12: A start in the middle of a byte discards the partial byte, produces no write request, and restarts device byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sel_a2 | input | 1 | Chip select strap compared with device byte bit 3 |
| busy_in | input | 1 | High while the page buffer commits to the array |
| mem_rdata | input | 8 | Read data for `mem_raddr`, combinational |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| mem_raddr | output | ADDR_W | Address counter, used as the read address |
| wr_valid | output | 1 | One-cycle write request to the page buffer |
| wr_addr | output | ADDR_W | Address of the requested write |
| wr_data | output | 8 | Data of the requested write |
| wr_commit | output | 1 | One-cycle pulse to start the nonvolatile write |

## Verification
The bench builds the engine with its defaults: a 10-bit address and a two-flop synchroniser. With a 1024-entry array, short writes and reads placed near location 1023 exercise counter roll-over in both directions. The bench drives each SCL phase for eight system clocks, which leaves margin over the three-to-four-cycle path from a bus edge to the pull-down. Its page buffer model holds `busy_in` for 400 cycles, which is longer than one device byte, so the first poll after every commit is refused and a later poll is accepted.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } twm_state_t;

endpackage

// File: rtl/twm_bus_sync.sv
// Synchronises both bus lines and derives edge and condition events
// from one consistent pair of current and previous samples.
module twm_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s    = scl_q[STAGES-1];
    assign sda_s    = sda_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twm_addr_ctr.sv
// Memory address counter; wraps naturally at 2**ADDR_W.
module twm_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + 1'b1;
    end

endmodule

// File: rtl/twm_eeprom_slave.sv
module twm_eeprom_slave
    import twm_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              sel_a2,
    input  logic              busy_in,
    input  logic [7:0]        mem_rdata,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);

    localparam int HI_W    = ADDR_W - 8;       // address bits in device byte
    localparam int SEL_BIT = HI_W + 1;         // chip select position
    localparam int CODE_W  = 7 - SEL_BIT;      // width of the type code

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    twm_state_t        state, nxt;
    logic [6:0]        sh;
    logic [2:0]        bitcnt;
    logic              hi_seen;
    logic              drive;
    logic              rw;
    logic [HI_W-1:0]   addr_hi;
    logic              data_seen;
    logic [ADDR_W-1:0] ctr;
    logic [7:0]        rx_byte;
    logic              last_bit, quiet, dev_match, ctr_load, ctr_inc;

    twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign rx_byte   = {sh, sda_s};
    assign last_bit  = (bitcnt == 3'd7);
    assign quiet     = !busy_in && !start_ev && !stop_ev;
    assign dev_match = (rx_byte[7 -: CODE_W] == DEV_CODE[3 -: CODE_W])
                       && (rx_byte[SEL_BIT] == sel_a2);
    assign ctr_load  = quiet && (state == ST_ADR) && scl_rise && last_bit;
    assign ctr_inc   = quiet && last_bit &&
                       (((state == ST_WR) && scl_rise) || ((state == ST_RD) && scl_fall));

    twm_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load),
        .load_val({addr_hi, rx_byte}), .inc(ctr_inc), .value(ctr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (busy_in)       nxt = ST_IDLE;
        else if (start_ev) nxt = ST_DEV;
        else if (stop_ev)  nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_DEV:     if (scl_rise && last_bit) nxt = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall && hi_seen)  nxt = rw ? ST_RD : ST_ADR;
                ST_ADR:     if (scl_rise && last_bit) nxt = ST_ADR_ACK;
                ST_ADR_ACK: if (scl_fall && hi_seen)  nxt = ST_WR;
                ST_WR:      if (scl_rise && last_bit) nxt = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall && hi_seen)  nxt = ST_WR;
                ST_RD:      if (scl_fall && last_bit) nxt = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_s)           nxt = ST_IDLE;
                    else if (scl_fall && hi_seen)    nxt = ST_RD;
                end
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            bitcnt    <= '0;
            hi_seen   <= 1'b0;
            drive     <= 1'b0;
            rw        <= 1'b0;
            addr_hi   <= '0;
            data_seen <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            if (busy_in) begin
                drive <= 1'b0;
            end else if (start_ev) begin
                bitcnt  <= '0;
                hi_seen <= 1'b0;
                drive   <= 1'b0;
            end else if (stop_ev) begin
                drive     <= 1'b0;
                wr_commit <= data_seen;
                data_seen <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_ADR, ST_WR: begin
                        if (scl_rise) begin
                            sh     <= rx_byte[6:0];
                            bitcnt <= bitcnt + 3'd1;
                            if (last_bit) begin
                                hi_seen <= 1'b0;
                                if (state == ST_DEV) begin
                                    rw      <= rx_byte[0];
                                    addr_hi <= rx_byte[HI_W:1];
                                end
                                if (state == ST_WR) begin
                                    wr_valid  <= 1'b1;
                                    wr_addr   <= ctr;
                                    wr_data   <= rx_byte;
                                    data_seen <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK, ST_ADR_ACK, ST_WR_ACK: begin
                        if (scl_rise) hi_seen <= 1'b1;
                        if (scl_fall) begin
                            if (hi_seen) begin
                                bitcnt  <= '0;
                                hi_seen <= 1'b0;
                                if (state == ST_DEV_ACK && rw) begin
                                    sh    <= mem_rdata[6:0];
                                    drive <= ~mem_rdata[7];
                                end else begin
                                    drive <= 1'b0;
                                end
                            end else begin
                                drive <= 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (last_bit) begin
                                drive  <= 1'b0;
                                bitcnt <= '0;
                            end else begin
                                drive  <= ~sh[6];
                                sh     <= {sh[5:0], 1'b0};
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) hi_seen <= 1'b1;
                        if (scl_fall && hi_seen) begin
                            sh      <= mem_rdata[6:0];
                            drive   <= ~mem_rdata[7];
                            hi_seen <= 1'b0;
                            bitcnt  <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull  = drive;
    assign mem_raddr = ctr;

endmodule

// File: rtl/twm_slave_checker.sv
module twm_slave_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_in,
    input logic              sda_pull,
    input logic              scl_s,
    input logic              stop_ev,
    input logic              wr_valid,
    input logic              wr_commit,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] mem_raddr
);

    p_pull_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_pull) |-> !scl_s);

    p_busy_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> !sda_pull);

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R4 and R8: counter already points past the written byte, with wrap
    p_ctr_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> mem_raddr == ADDR_W'(wr_addr + 1'b1));

    p_commit_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_ev));

    p_commit_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

bind twm_eeprom_slave twm_slave_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .sda_pull(sda_pull),
    .scl_s(scl_s), .stop_ev(stop_ev), .wr_valid(wr_valid),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .mem_raddr(mem_raddr)
);

// File: tb/twm_eeprom_slave_tb.sv
module twm_eeprom_slave_tb_top;

    localparam int AW       = 10;
    localparam int DEPTH    = 1 << AW;
    localparam int H        = 8;
    localparam int BUSY_CYC = 400;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, scl_m, sda_m, sel_a2, busy_in, sda_line;
    logic [7:0]    mem_rdata, wr_data;
    logic          sda_pull, wr_valid, wr_commit;
    logic [AW-1:0] mem_raddr, wr_addr;

    logic [7:0] mem     [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    logic [7:0] pend_d  [DEPTH];
    logic       pend_v  [DEPTH];
    int total = 0, bad = 0, wv_cnt = 0, cm_cnt = 0, busy_cnt = 0, exp_ctr = 0;

    assign sda_line  = sda_m & ~sda_pull;
    assign mem_rdata = mem[mem_raddr];
    assign busy_in   = (busy_cnt != 0);

    twm_eeprom_slave #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sel_a2(sel_a2), .busy_in(busy_in), .mem_rdata(mem_rdata),
        .sda_pull(sda_pull), .mem_raddr(mem_raddr), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    // Page buffer and array model
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]     = 8'(i * 7 + 3);
                exp_mem[i] = 8'(i * 7 + 3);
                pend_v[i]  = 1'b0;
                pend_d[i]  = 8'h00;
            end
            busy_cnt = 0;
        end else begin
            if (wr_valid) begin
                pend_d[wr_addr] = wr_data;
                pend_v[wr_addr] = 1'b1;
                wv_cnt++;
            end
            if (wr_commit) begin
                cm_cnt++;
                for (int i = 0; i < DEPTH; i++)
                    if (pend_v[i]) begin mem[i] = pend_d[i]; pend_v[i] = 1'b0; end
                busy_cnt = BUSY_CYC;
            end else if (busy_cnt > 0) begin
                busy_cnt--;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic rw, input logic [AW-1:0] a, input logic sel);
        return {4'b1010, sel, a[AW-1:8], rw};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(H);
        if (!scl_m) begin scl_m = 1'b1; wait_clk(H); end
        sda_m = 1'b0;
        wait_clk(H);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H);
        sda_m = 1'b1;
        wait_clk(H);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H / 2);
        r = sda_line;
        wait_clk(H / 2);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
        clk_bit(!give_ack, r);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input int n, input logic [7:0] d [4]);
        logic ack;
        bus_start();
        send_byte(dev_byte(1'b0, a, 1'b1), ack);
        chk("R4 device byte ack in write", ack, 1);
        send_byte(a[7:0], ack);
        chk("R5 address byte ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);
            chk("R4 data byte ack", ack, 1);
            exp_mem[(int'(a) + i) % DEPTH] = d[i];
        end
        wait_clk(4);
        chk("R3 ack released after ninth clock", sda_pull, 0);
        bus_stop();
        exp_ctr = (int'(a) + n) % DEPTH;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int n, input logic random_addr);
        logic ack;
        logic [7:0] b;
        int base;
        bus_start();
        if (random_addr) begin
            send_byte(dev_byte(1'b0, a, 1'b1), ack);
            chk("R9 dummy write device ack", ack, 1);
            send_byte(a[7:0], ack);
            chk("R9 dummy write address ack", ack, 1);
            bus_start();
            base = int'(a);
        end else begin
            base = exp_ctr;
        end
        send_byte(dev_byte(1'b1, AW'(base), 1'b1), ack);
        chk("R6 read device byte ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(random_addr ? "R9 R7 R8 sequential read data" : "R6 current address read data",
                b, exp_mem[(base + i) % DEPTH]);
        end
        wait_clk(4);
        chk("R7 released after master nack", sda_pull, 0);
        bus_stop();
        exp_ctr = (base + n) % DEPTH;
    endtask

    task automatic poll_ready(input string tag);
        logic ack;
        int tries = 0;
        ack = 1'b0;
        while (!ack && tries < 40) begin
            bus_start();
            send_byte(dev_byte(1'b0, 0, 1'b1), ack);
            bus_stop();
            if (tries == 0) chk(tag, ack, 0);
            tries++;
        end
        chk("R10 poll accepted once commit ends", ack, 1);
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        logic [7:0] d [4];
        int wv0, cm0;
        void'($urandom(32'd5151));
        sda_m = 1'b1; scl_m = 1'b1; sel_a2 = 1'b1; rst_n = 1'b0;
        wait_clk(5);
        chk("R1 reset pull-down off", sda_pull, 0);
        chk("R1 reset no write request", wr_valid, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R2: wrong type code, then wrong select bit
        bus_start();
        send_byte(8'b1011_1000, ack);
        chk("R2 wrong type code refused", ack, 0);
        bus_stop();
        bus_start();
        send_byte(dev_byte(1'b0, 0, 1'b0), ack);
        chk("R2 select mismatch refused", ack, 0);
        bus_stop();

        // R4 R8 R11: write across the top of the array
        wv0 = wv_cnt; cm0 = cm_cnt;
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h00;
        do_write(10'h3FE, 3, d);
        wait_clk(2);
        chk("R4 one request per data byte", wv_cnt - wv0, 3);
        chk("R11 one commit after data", cm_cnt - cm0, 1);
        chk("R8 write rolled into location 0", mem[0], 8'h33);

        // R10: refused while busy, then accepted; address-only stop has no commit
        poll_ready("R10 poll refused during commit");
        chk("R11 no commit without data", cm_cnt - cm0, 1);

        // R6: two current-address reads, counter advanced from last write
        do_read(0, 1, 1'b0);
        do_read(0, 1, 1'b0);

        // R9 R7 R8: random read through the roll-over point
        do_read(10'h3FE, 4, 1'b1);

        // R12: start in the middle of a data byte
        wv0 = wv_cnt; cm0 = cm_cnt;
        bus_start();
        send_byte(dev_byte(1'b0, 10'h010, 1'b1), ack);
        send_byte(8'h10, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
        bus_start();
        send_byte(dev_byte(1'b1, 10'h010, 1'b1), ack);
        chk("R12 device byte after abort acked", ack, 1);
        recv_byte(1'b0, b);
        chk("R12 read at loaded address", b, exp_mem[16]);
        bus_stop();
        wait_clk(2);
        chk("R12 partial byte gave no request", wv_cnt - wv0, 0);
        chk("R12 partial byte gave no commit", cm_cnt - cm0, 0);
        exp_ctr = 17;

        // R1: stop returns to standby, next start works
        bus_start();
        send_byte(dev_byte(1'b0, 0, 1'b1), ack);
        chk("R1 accepted after stop and start", ack, 1);
        bus_stop();

        // Random writes and reads
        for (int it = 0; it < 14; it++) begin
            logic [AW-1:0] a;
            int n;
            a = AW'($urandom_range(0, DEPTH - 1));
            n = $urandom_range(1, 4);
            for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
            do_write(a, n, d);
            poll_ready("R10 random poll refused during commit");
            do_read(a, n, 1'b1);
            if ($urandom_range(0, 1) == 1) do_read(0, 2, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule